// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of memory segments into a table of 8-byte transfer descriptors. A scatter-gather DMA engine later walks that table. Each segment arrives over a valid/ready handshake with a 32-bit bus address, a 17-bit byte length and a flag that marks the last segment of a request. The block writes the descriptors one per cycle through a write-enable memory port. The port carries a descriptor index and one 64-bit word.

The engine can only start a transfer on a 4-byte boundary. A segment that starts off that boundary is therefore cut in two. The first 1 to 3 bytes go to a 4-byte slot in a separate aligned bounce area. The rest of the segment gets its own descriptor. After the last segment the block closes the table with an end marker. It then pulses `done` and reports how many descriptors and bytes it wrote. If the table or the bounce area runs out of room, the block raises a sticky overflow flag and stops writing. It still accepts segments until the last one, so the source never stalls.

Top module: `sg_table_builder`

## Requirements
- R1: After reset `seg_ready`, `desc_we` and `done` are low, both error flags are low and `desc_count` is 0. `seg_ready` stays low until `start` is seen while idle.
- R2: A segment whose address has bits [1:0] = 0 produces one descriptor. Its 64-bit word holds the attribute 0x21 in bits [7:0], zero in bits [15:8], the length in bits [31:16] and the address in bits [63:32].
- R3: A segment with a nonzero address offset first produces a head descriptor with attribute 0x21. Its length is (4 - (addr mod 4)) mod 4 and its address is BOUNCE_BASE + 4*k, where k counts the head descriptors already written in this table.
- R4: After its head descriptor, an unaligned segment produces a body descriptor with attribute 0x21, address addr + head and length len - head.
- R5: A segment whose length does not exceed its head length produces only the head descriptor, with the length cut to the segment length.
- R6: A length of exactly 65536 is accepted and stored as 0 in the 16-bit length field.
- R7: A segment of length 0 or above 65536 writes no descriptor and sets the sticky `err_len` flag. The segments after it are still converted.
- R8: After the last segment the block writes a terminator whose word is 0x03 in bits [7:0] and zero elsewhere.
- R9: `done` is high for exactly one cycle at the end of a table. While it is high, `desc_count` equals the number of descriptors written, terminator included, and `table_bytes` is 8 times that number.
- R10: The last table slot (index 2*MAX_SEGS) is held for the terminator, and at most MAX_SEGS head descriptors fit in the bounce area. A head or body descriptor that does not fit is not written and sets `err_ovf`. After that, no descriptor is written, not even the terminator. Segments are still accepted until the last one, and then `done` pulses.
- R11: Each `start` given while idle begins a new table at index 0 and bounce slot 0 and clears both error flags. A `start` given while a table is being built has no effect.
- R12: Descriptor indices run 0, 1, 2, ... with no gap and no repeat within a table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new table (honoured only while idle) |
| seg_valid | input | 1 | Segment on the inputs is valid |
| seg_ready | output | 1 | Block accepts a segment this cycle |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | 17 | Segment length in bytes (1 to 65536 is legal) |
| seg_last | input | 1 | Marks the final segment of the table |
| desc_we | output | 1 | Descriptor write strobe |
| desc_idx | output | IDX_W | Descriptor index being written |
| desc_wdata | output | 64 | Descriptor word, byte 0 in bits [7:0] |
| done | output | 1 | One-cycle table-complete pulse |
| desc_count | output | CNT_W | Descriptors written in the current table |
| table_bytes | output | CNT_W+3 | Bytes written in the current table |
| err_len | output | 1 | Sticky illegal-length flag |
| err_ovf | output | 1 | Sticky table or bounce-area overflow flag |

## Verification
On every cycle, the bound checker tests the local rules. Every written word must be a legal data or terminator word with a zero reserved byte. Each write must raise the count by one and stay inside the table. A terminator must be followed at once by `done`. The overflow flag must stay set and block further writes, and the write, ready and done strobes must never overlap. Only the bench scenarios can show that the whole table is right: the split points, the bounce-slot addresses, the length clipping and the 65536 encoding. The same holds for skipping illegal lengths, the two separate overflow limits, draining after overflow, and the rule that a `start` while busy is ignored. For these, each captured table is compared against a model built from the requirements.

// File: rtl/sgt_pkg.sv
package sgt_pkg;
   localparam int BUS_AW  = 32;
   localparam int FIELD_W = 16;
   localparam int SEGLEN_W = 17;

   localparam logic [7:0] ATTR_XFER = 8'h21;
   localparam logic [7:0] ATTR_END  = 8'h03;

   // 64-bit little-endian descriptor word: attr lands in byte 0
   typedef struct packed {
      logic [BUS_AW-1:0]  addr;
      logic [FIELD_W-1:0] len;
      logic [7:0]         rsvd;
      logic [7:0]         attr;
   } desc_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_TAKE, ST_HEAD, ST_BODY, ST_TERM, ST_DRAIN, ST_FIN
   } bld_state_t;
endpackage

// File: rtl/sgt_split.sv
module sgt_split
   import sgt_pkg::*;
(
   input  logic [BUS_AW-1:0]   seg_a,
   input  logic [SEGLEN_W-1:0] seg_l,
   output logic [SEGLEN_W-1:0] head_len,
   output logic [BUS_AW-1:0]   body_addr,
   output logic [SEGLEN_W-1:0] body_len,
   output logic                has_body
);
   logic [1:0]          head_raw;
   logic [SEGLEN_W-1:0] head_ext;

   always_comb begin
      head_raw  = 2'(3'd4 - {1'b0, seg_a[1:0]});
      head_ext  = {{(SEGLEN_W-2){1'b0}}, head_raw};
      head_len  = (seg_l < head_ext) ? seg_l : head_ext;
      has_body  = (seg_l > head_ext);
      body_len  = seg_l - head_ext;
      body_addr = seg_a + {{(BUS_AW-2){1'b0}}, head_raw};
   end
endmodule

// File: rtl/sgt_slot_ctr.sv
module sgt_slot_ctr
   import sgt_pkg::*;
#(
   parameter int                SLOTS = 128,
   parameter logic [BUS_AW-1:0] BASE  = 32'h0001_0000,
   localparam int               SC_W  = $clog2(SLOTS+1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              adv,
   output logic [BUS_AW-1:0] slot_addr,
   output logic              full
);
   logic [SC_W-1:0] used;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   used <= '0;
      else if (clr) used <= '0;
      else if (adv) used <= used + 1'b1;
   end

   assign full      = (used == SC_W'(SLOTS));
   assign slot_addr = BASE + (BUS_AW'(used) << 2);
endmodule

// File: rtl/sgt_pack.sv
module sgt_pack
   import sgt_pkg::*;
(
   input  logic [7:0]          attr,
   input  logic [SEGLEN_W-1:0] len,
   input  logic [BUS_AW-1:0]   addr,
   output logic [63:0]         word
);
   desc_t d;
   always_comb begin
      d.attr = attr;
      d.rsvd = 8'h00;
      d.len  = len[FIELD_W-1:0];
      d.addr = addr;
   end
   assign word = d;
endmodule

// File: rtl/sg_table_builder.sv
module sg_table_builder
   import sgt_pkg::*;
#(
   parameter int                MAX_SEGS    = 128,
   parameter logic [BUS_AW-1:0] BOUNCE_BASE = 32'h0001_0000,
   localparam int               MAX_DESC    = 2*MAX_SEGS + 1,
   localparam int               IDX_W       = $clog2(MAX_DESC),
   localparam int               CNT_W       = $clog2(MAX_DESC+1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                seg_valid,
   output logic                seg_ready,
   input  logic [BUS_AW-1:0]   seg_addr,
   input  logic [SEGLEN_W-1:0] seg_len,
   input  logic                seg_last,
   output logic                desc_we,
   output logic [IDX_W-1:0]    desc_idx,
   output logic [63:0]         desc_wdata,
   output logic                done,
   output logic [CNT_W-1:0]    desc_count,
   output logic [CNT_W+2:0]    table_bytes,
   output logic                err_len,
   output logic                err_ovf
);
   if (MAX_SEGS < 1) begin : g_bad_segs
      $error("sg_table_builder: MAX_SEGS must be at least 1");
   end
   if (BOUNCE_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("sg_table_builder: BOUNCE_BASE must be 4-byte aligned");
   end

   localparam logic [SEGLEN_W-1:0] LEN_MAX = SEGLEN_W'(65536);

   bld_state_t          state;
   logic [CNT_W-1:0]    idx;
   logic [BUS_AW-1:0]   cur_addr;
   logic [SEGLEN_W-1:0] cur_len;
   logic                cur_last;
   logic                err_len_q, err_ovf_q;

   logic [SEGLEN_W-1:0] head_len, body_len;
   logic [BUS_AW-1:0]   body_addr, slot_addr;
   logic                has_body, slot_full, room, in_bad, take;
   logic [7:0]          w_attr;
   logic [SEGLEN_W-1:0] w_len;
   logic [BUS_AW-1:0]   w_addr;

   sgt_split u_split (
      .seg_a(cur_addr), .seg_l(cur_len), .head_len(head_len),
      .body_addr(body_addr), .body_len(body_len), .has_body(has_body)
   );

   sgt_slot_ctr #(.SLOTS(MAX_SEGS), .BASE(BOUNCE_BASE)) u_slots (
      .clk(clk), .rst_n(rst_n),
      .clr(state == ST_IDLE && start),
      .adv(state == ST_HEAD && room && !slot_full),
      .slot_addr(slot_addr), .full(slot_full)
   );

   sgt_pack u_pack (.attr(w_attr), .len(w_len), .addr(w_addr), .word(desc_wdata));

   assign room   = (idx < CNT_W'(MAX_DESC-1));
   assign in_bad = (seg_len == '0) || (seg_len > LEN_MAX);
   assign take   = seg_valid && seg_ready;

   always_comb begin
      case (state)
         ST_HEAD: begin w_attr = ATTR_XFER; w_len = head_len; w_addr = slot_addr; end
         ST_BODY: begin w_attr = ATTR_XFER; w_len = body_len; w_addr = body_addr; end
         default: begin w_attr = ATTR_END;  w_len = '0;       w_addr = '0;        end
      endcase
   end

   assign seg_ready   = (state == ST_TAKE) || (state == ST_DRAIN);
   assign desc_we     = (state == ST_HEAD && room && !slot_full) ||
                        (state == ST_BODY && room) || (state == ST_TERM);
   assign desc_idx    = idx[IDX_W-1:0];
   assign done        = (state == ST_FIN);
   assign desc_count  = idx;
   assign table_bytes = {idx, 3'b000};
   assign err_len     = err_len_q;
   assign err_ovf     = err_ovf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         idx       <= '0;
         cur_addr  <= '0;
         cur_len   <= '0;
         cur_last  <= 1'b0;
         err_len_q <= 1'b0;
         err_ovf_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               idx       <= '0;
               err_len_q <= 1'b0;
               err_ovf_q <= 1'b0;
               state     <= ST_TAKE;
            end
            ST_TAKE: if (take) begin
               cur_addr <= seg_addr;
               cur_len  <= seg_len;
               cur_last <= seg_last;
               if (in_bad) begin
                  err_len_q <= 1'b1;
                  state     <= seg_last ? ST_TERM : ST_TAKE;
               end else if (seg_addr[1:0] != 2'b00) begin
                  state <= ST_HEAD;
               end else begin
                  state <= ST_BODY;
               end
            end
            ST_HEAD: if (!room || slot_full) begin
               err_ovf_q <= 1'b1;
               state     <= cur_last ? ST_FIN : ST_DRAIN;
            end else begin
               idx   <= idx + 1'b1;
               state <= has_body ? ST_BODY : (cur_last ? ST_TERM : ST_TAKE);
            end
            ST_BODY: if (!room) begin
               err_ovf_q <= 1'b1;
               state     <= cur_last ? ST_FIN : ST_DRAIN;
            end else begin
               idx   <= idx + 1'b1;
               state <= cur_last ? ST_TERM : ST_TAKE;
            end
            ST_TERM: begin
               idx   <= idx + 1'b1;
               state <= ST_FIN;
            end
            ST_DRAIN: if (take && seg_last) state <= ST_FIN;
            ST_FIN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sg_table_builder_chk.sv
module sg_table_builder_chk #(
   parameter int MAX_DESC = 257,
   parameter int IDX_W    = 9,
   parameter int CNT_W    = 9
)(
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             seg_ready,
   input logic             desc_we,
   input logic [IDX_W-1:0] desc_idx,
   input logic [63:0]      desc_wdata,
   input logic             done,
   input logic [CNT_W-1:0] desc_count,
   input logic             err_ovf
);
   // R2
   legal_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> (desc_wdata[15:8] == 8'h00) &&
                  ((desc_wdata[7:0] == 8'h21) ||
                   (desc_wdata[7:0] == 8'h03 && desc_wdata[63:16] == '0)));
   // R8
   term_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_we && desc_wdata[7:0] == 8'h03) |=> done);
   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> (32'(desc_idx) < MAX_DESC));
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovf && !start) |=> err_ovf);
   // R10
   ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |-> !desc_we);
   // R12
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |=> desc_count == $past(desc_count) + 1'b1);
   // R1
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, seg_ready, desc_we}));
endmodule

bind sg_table_builder sg_table_builder_chk #(
   .MAX_DESC(MAX_DESC), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .seg_ready(seg_ready),
   .desc_we(desc_we), .desc_idx(desc_idx), .desc_wdata(desc_wdata),
   .done(done), .desc_count(desc_count), .err_ovf(err_ovf)
);

// File: tb/sg_table_builder_test.sv
module sg_table_builder_test;
   localparam int          MAXS = 4;
   localparam int          MAXD = 2*MAXS + 1;
   localparam int          IW   = $clog2(MAXD);
   localparam int          CW   = $clog2(MAXD+1);
   localparam logic [31:0] BB   = 32'h0000_F000;

   // {addr, len, last}
   localparam int NV = 10;
   localparam logic [49:0] VEC [NV] = '{
      {32'h1000_0000, 17'h00200, 1'b0},
      {32'h2000_0001, 17'h00100, 1'b0},
      {32'h2000_0106, 17'h00010, 1'b0},
      {32'h3000_0003, 17'h00001, 1'b1},
      {32'h4000_0002, 17'h00001, 1'b0},
      {32'h5000_0000, 17'h10000, 1'b0},
      {32'h5000_0004, 17'h10001, 1'b0},
      {32'h6000_0001, 17'h00000, 1'b0},
      {32'h7000_0005, 17'h10000, 1'b1},
      {32'h0800_0007, 17'h00004, 1'b1}
   };

   logic          clk = 0, rst_n = 0, start = 0, seg_valid = 0, seg_last = 0;
   logic [31:0]   seg_addr = '0;
   logic [16:0]   seg_len = '0;
   logic          seg_ready, desc_we, done, err_len, err_ovf;
   logic [IW-1:0] desc_idx;
   logic [63:0]   desc_wdata;
   logic [CW-1:0] desc_count;
   logic [CW+2:0] table_bytes;

   sg_table_builder #(.MAX_SEGS(MAXS), .BOUNCE_BASE(BB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .seg_valid(seg_valid),
      .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .seg_last(seg_last), .desc_we(desc_we), .desc_idx(desc_idx),
      .desc_wdata(desc_wdata), .done(done), .desc_count(desc_count),
      .table_bytes(table_bytes), .err_len(err_len), .err_ovf(err_ovf)
   );

   always #10 clk = ~clk;

   int nchk = 0, nerr = 0, cap_n = 0, done_seen = 0, sl_n = 0, exp_n = 0;
   logic [63:0] cap_w [16];
   int          cap_i [16];
   logic [63:0] exp_w [16];
   logic [31:0] sl_a [16];
   int          sl_l [16];
   bit          exp_el, exp_ov, finished = 0;
   int          d_cnt, d_bytes;
   bit          d_el, d_ov;

   always @(negedge clk) begin
      if (desc_we && cap_n < 16) begin
         cap_w[cap_n] = desc_wdata;
         cap_i[cap_n] = int'(desc_idx);
         cap_n++;
      end
      if (done) begin
         done_seen++;
         d_cnt = int'(desc_count); d_bytes = int'(table_bytes);
         d_el = err_len; d_ov = err_ovf;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input logic [7:0] at, input int ln, input logic [31:0] ad);
      logic [15:0] l16 = ln[15:0];
      return {ad, l16, 8'h00, at};
   endfunction

   // expected table from the requirements
   task automatic build_model();
      int n = 0, s = 0;
      exp_el = 0; exp_ov = 0;
      for (int k = 0; k < sl_n; k++) begin
         logic [31:0] a = sl_a[k];
         int l = sl_l[k];
         int h = (4 - int'(a[1:0])) & 3;
         if (exp_ov) continue;
         if (l == 0 || l > 65536) begin exp_el = 1; continue; end     // R7
         if (h != 0) begin                                            // R3 R5
            if (s >= MAXS || n >= MAXD-1) begin exp_ov = 1; continue; end
            exp_w[n] = mk(8'h21, (l < h) ? l : h, BB + 32'(4*s)); n++; s++;
         end
         if (l > h) begin                                             // R2 R4 R6
            if (n >= MAXD-1) begin exp_ov = 1; continue; end
            exp_w[n] = mk(8'h21, l - h, a + 32'(h)); n++;
         end
      end
      if (!exp_ov) begin exp_w[n] = mk(8'h03, 0, 32'h0); n++; end    // R8
      exp_n = n;
   endtask

   task automatic begin_table();
      cap_n = 0; done_seen = 0; sl_n = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
   endtask

   task automatic send(input logic [31:0] a, input int l, input bit last);
      seg_addr = a; seg_len = 17'(l); seg_last = last; seg_valid = 1;
      sl_a[sl_n] = a; sl_l[sl_n] = l; sl_n++;
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
      seg_valid = 0; seg_last = 0;
   endtask

   task automatic finish_table(input string tag);
      int t = 0;
      while (done_seen == 0 && t < 2000) begin @(negedge clk); t++; end
      @(negedge clk);
      build_model();
      chk(done_seen == 1, {"R9 done pulse once ", tag}, done_seen, 1);
      chk(d_cnt == exp_n, {"R9 desc_count ", tag}, d_cnt, exp_n);
      chk(d_bytes == 8*exp_n, {"R9 table_bytes ", tag}, d_bytes, 8*exp_n);
      chk(cap_n == exp_n, {"R12 number of writes ", tag}, cap_n, exp_n);
      chk(d_el == exp_el, {"R7 err_len ", tag}, d_el, exp_el);
      chk(d_ov == exp_ov, {"R10 err_ovf ", tag}, d_ov, exp_ov);
      for (int k = 0; k < exp_n && k < cap_n; k++) begin
         chk(cap_i[k] == k, {"R12 index ", tag}, cap_i[k], k);
         chk(cap_w[k] == exp_w[k], {"R2 R3 R4 R5 R6 R8 word ", tag}, cap_w[k], exp_w[k]);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=expired expected=finished");
      summary();
   end

   initial begin
      bit open;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!seg_ready && !desc_we && !done, "R1 strobes after reset", {seg_ready, desc_we, done}, 0);
      chk(!err_len && !err_ovf && desc_count == 0, "R1 flags after reset", {err_len, err_ovf}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(!seg_ready, "R1 not ready before start", seg_ready, 0);

      // vector walk: R2 R3 R4 R5 R6 R7 R8
      open = 0;
      for (int v = 0; v < NV; v++) begin
         if (!open) begin begin_table(); open = 1; end
         send(VEC[v][49:18], int'(VEC[v][17:1]), VEC[v][0]);
         if (VEC[v][0]) begin finish_table($sformatf("vec%0d", v)); open = 0; end
      end

      // R10 table full: aligned segments, overflow at the 9th, 10th drained
      begin_table();
      for (int k = 0; k < 10; k++) send(32'h8000_0000 + 32'(k*256), 64, k == 9);
      finish_table("table limit");

      // R10 bounce area full: head-only segments (R5), 5th head overflows
      begin_table();
      for (int k = 0; k < 5; k++) send(32'h9000_0011 + 32'(k*16), 1, 1'b0);
      send(32'h9100_0000, 8, 1'b1);
      finish_table("bounce limit");

      // R11 new table clears errors and restarts at index 0
      begin_table();
      send(32'hA000_0000, 12, 1'b1);
      finish_table("restart");

      // R11 start while busy has no effect
      begin_table();
      send(32'hB000_0002, 40, 1'b0);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      send(32'hB100_0000, 20, 1'b1);
      finish_table("start busy");

      summary();
   end
endmodule